// File: doc/BRIEF.md
# Multi-Channel Gamma Correction Table

This block applies gamma correction to 24-bit RGB pixels for several display channels. All channels share one flat table address space. A channel's table takes 768 consecutive addresses: 256 red entries, then 256 green, then 256 blue. Channel c starts at address c × 768, and the channels follow one another in ascending order. Each entry is 8 bits wide. Each of the three colour components of a pixel is corrected on its own: the component value is the index into that channel's table for that component.

Software loads the tables through two write ports. The first is an address write, which also carries an auto-advance flag. The second is a data write, which stores one entry at the current address. Each channel has its own enable bit. With the bit clear, that channel's pixels pass through unchanged. When every enable bit is clear, the table storage is considered lost. Corrected output stays off until the table is written again.

Each pixel arrives with a valid strobe and a channel number. Its corrected value appears on the registered output exactly one clock later.

Top module: `gamma_lut_top`

## Requirements
- R1: After reset, out_valid is 0, out_rgb is 0, the table address is 0 and auto-advance is off.
- R2: The data write at flat address A = c×768 + k×256 + v fills the entry used for component k of channel c at component value v. Component k is 0 for red, 1 for green and 2 for blue.
- R3: The auto-advance flag is latched with each accepted address write. While the flag is set, every stored data write moves the address on by one. While it is clear, the address stays put, so repeated data writes overwrite the same entry.
- R4: An address write with a value of 2304 or more is ignored. Neither the address nor the auto-advance flag changes.
- R5: The address never goes past 2304. A data write made while the address equals 2304 stores nothing, so no entry changes, including entry 0.
- R6: The red, green and blue fields are pix_rgb[23:16], [15:8] and [7:0]. When a pixel is corrected, each field is replaced by its own table entry, indexed by that field's value.
- R7: out_valid equals pix_valid from the previous cycle. out_rgb changes only in the cycle after a valid pixel and holds otherwise.
- R8: A pixel whose channel has its gamma_en bit clear comes out unchanged. Other channels are not affected.
- R9: The table becomes invalid after reset, and again after any cycle in which every gamma_en bit is clear and no entry is stored. While it is invalid, every pixel passes unchanged. The next stored data write makes it valid again.
- R10: A pixel with a channel number of 3 or more passes through unchanged.
- R11: A pixel looked up in the same cycle as a data write to the entry it uses sees the entry's old contents. The next pixel sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr_we | input | 1 | Address write strobe |
| host_addr_wdata | input | 12 | New table address |
| host_addr_autoinc | input | 1 | Auto-advance flag latched with the address |
| host_data_we | input | 1 | Data write strobe |
| host_data_wdata | input | 8 | Entry value |
| gamma_en | input | 3 | Per-channel correction enable, bit c for channel c |
| pix_valid | input | 1 | Input pixel strobe |
| pix_ch | input | 2 | Channel number of the input pixel |
| pix_rgb | input | 24 | Input pixel, red in the top byte |
| out_valid | output | 1 | Output pixel strobe |
| out_rgb | output | 24 | Corrected or passed-through pixel |

## Verification
The hardest state to reach from the ports is the address stopped at one past the last entry. Getting there takes a full auto-advancing fill, or a jump to the final entry followed by extra data writes. Once there, the bench shows that nothing wrapped round to entry 0 by probing entry 0 and the last blue entry with pixels. Loss of table contents is reached by dropping every enable for a cycle. The bench then checks that pixels pass unchanged until a single write revalidates the table. A data write and a pixel hitting the same entry in the same cycle are lined up deliberately to show the ordering.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

  localparam int NUM_COMPS = 3;

  typedef enum logic [1:0] {
    COMP_RED = 2'd0,
    COMP_GRN = 2'd1,
    COMP_BLU = 2'd2
  } comp_e;

endpackage

// File: rtl/gamma_rst_sync.sv
module gamma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/gamma_host_port.sv
module gamma_host_port
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int COMP_W  = 8,
  parameter int ADDR_W  = 12,
  parameter int CH_W    = 2,
  parameter int BANK_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_we,
  input  logic [ADDR_W-1:0]  addr_wdata,
  input  logic               addr_autoinc,
  input  logic               data_we,
  input  logic [COMP_W-1:0]  data_wdata,
  input  logic [NUM_CH-1:0]  gamma_en,
  output logic               wr_en,
  output comp_e              wr_comp,
  output logic [BANK_AW-1:0] wr_row,
  output logic [COMP_W-1:0]  wr_data,
  output logic               table_valid
);

  localparam int ENTRIES = 1 << COMP_W;
  localparam int CH_SPAN = NUM_COMPS * ENTRIES;
  localparam int TOTAL   = NUM_CH * CH_SPAN;

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              inc_q, inc_d;
  logic              tv_q, tv_d;
  logic              ptr_in_range;
  logic              addr_ok;
  logic [CH_W-1:0]   ch_sel;
  logic [COMP_W+1:0] ch_off;

  assign ptr_in_range = ptr_q < ADDR_W'(TOTAL);
  assign addr_ok      = addr_wdata < ADDR_W'(TOTAL);
  assign wr_en        = data_we && ptr_in_range;

  // split the flat address into channel, component and entry index
  assign ch_sel  = CH_W'(ptr_q / ADDR_W'(CH_SPAN));
  assign ch_off  = (COMP_W + 2)'(ptr_q % ADDR_W'(CH_SPAN));
  assign wr_comp = comp_e'(ch_off[COMP_W +: 2]);
  assign wr_row  = {ch_sel, ch_off[COMP_W-1:0]};
  assign wr_data = data_wdata;

  always_comb begin
    ptr_d = ptr_q;
    inc_d = inc_q;
    if (addr_we && addr_ok) begin
      ptr_d = addr_wdata;
      inc_d = addr_autoinc;
    end else if (wr_en && inc_q) begin
      ptr_d = ptr_q + ADDR_W'(1);
    end
  end

  always_comb begin
    tv_d = tv_q;
    if (wr_en) begin
      tv_d = 1'b1;
    end else if (gamma_en == '0) begin
      tv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      inc_q <= 1'b0;
      tv_q  <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      inc_q <= inc_d;
      tv_q  <= tv_d;
    end
  end

  assign table_valid = tv_q;

endmodule

// File: rtl/gamma_bank.sv
module gamma_bank #(
  parameter int DEPTH = 768,
  parameter int AW    = 10,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/gamma_pixel_pipe.sv
module gamma_pixel_pipe
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int COMP_W  = 8,
  parameter int CH_W    = 2,
  parameter int BANK_AW = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pix_valid,
  input  logic [CH_W-1:0]               pix_ch,
  input  logic [NUM_COMPS*COMP_W-1:0]   pix_rgb,
  input  logic [NUM_CH-1:0]             gamma_en,
  input  logic                          table_valid,
  output logic [BANK_AW-1:0]            lut_addr [NUM_COMPS],
  input  logic [COMP_W-1:0]             lut_data [NUM_COMPS],
  output logic                          out_valid,
  output logic [NUM_COMPS*COMP_W-1:0]   out_rgb
);

  logic                        ch_ok;
  logic                        use_lut;
  logic [NUM_COMPS*COMP_W-1:0] rgb_d, rgb_q;
  logic                        vld_q;

  assign ch_ok   = 32'(pix_ch) < NUM_CH;
  assign use_lut = ch_ok && gamma_en[pix_ch] && table_valid;

  for (genvar g = 0; g < NUM_COMPS; g++) begin : g_comp
    localparam int LSB = (NUM_COMPS - 1 - g) * COMP_W;
    assign lut_addr[g]          = ch_ok ? {pix_ch, pix_rgb[LSB +: COMP_W]} : '0;
    assign rgb_d[LSB +: COMP_W] = use_lut ? lut_data[g] : pix_rgb[LSB +: COMP_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rgb_q <= '0;
    end else begin
      vld_q <= pix_valid;
      if (pix_valid) begin
        rgb_q <= rgb_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_rgb   = rgb_q;

endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
  import gamma_lut_pkg::*;
#(
  parameter  int NUM_CH     = 3,
  parameter  int COMP_W     = 8,
  localparam int ENTRIES    = 1 << COMP_W,
  localparam int TOTAL      = NUM_CH * NUM_COMPS * ENTRIES,
  localparam int ADDR_W     = $clog2(TOTAL + 1),
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BANK_AW    = CH_W + COMP_W,
  localparam int BANK_DEPTH = NUM_CH * ENTRIES,
  localparam int PIX_W      = NUM_COMPS * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_addr_we,
  input  logic [ADDR_W-1:0] host_addr_wdata,
  input  logic              host_addr_autoinc,
  input  logic              host_data_we,
  input  logic [COMP_W-1:0] host_data_wdata,
  input  logic [NUM_CH-1:0] gamma_en,
  input  logic              pix_valid,
  input  logic [CH_W-1:0]   pix_ch,
  input  logic [PIX_W-1:0]  pix_rgb,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_rgb
);

  logic               rst_core_n;
  logic               wr_en;
  comp_e              wr_comp;
  logic [BANK_AW-1:0] wr_row;
  logic [COMP_W-1:0]  wr_data;
  logic               tbl_valid;
  logic [BANK_AW-1:0] lut_addr [NUM_COMPS];
  logic [COMP_W-1:0]  lut_data [NUM_COMPS];

  gamma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  gamma_host_port #(
    .NUM_CH  (NUM_CH),
    .COMP_W  (COMP_W),
    .ADDR_W  (ADDR_W),
    .CH_W    (CH_W),
    .BANK_AW (BANK_AW)
  ) u_host (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .addr_we      (host_addr_we),
    .addr_wdata   (host_addr_wdata),
    .addr_autoinc (host_addr_autoinc),
    .data_we      (host_data_we),
    .data_wdata   (host_data_wdata),
    .gamma_en     (gamma_en),
    .wr_en        (wr_en),
    .wr_comp      (wr_comp),
    .wr_row       (wr_row),
    .wr_data      (wr_data),
    .table_valid  (tbl_valid)
  );

  for (genvar g = 0; g < NUM_COMPS; g++) begin : g_bank
    gamma_bank #(
      .DEPTH (BANK_DEPTH),
      .AW    (BANK_AW),
      .DW    (COMP_W)
    ) u_bank (
      .clk   (clk),
      .we    (wr_en && (wr_comp == comp_e'(g))),
      .waddr (wr_row),
      .wdata (wr_data),
      .raddr (lut_addr[g]),
      .rdata (lut_data[g])
    );
  end

  gamma_pixel_pipe #(
    .NUM_CH  (NUM_CH),
    .COMP_W  (COMP_W),
    .CH_W    (CH_W),
    .BANK_AW (BANK_AW)
  ) u_pipe (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .pix_valid   (pix_valid),
    .pix_ch      (pix_ch),
    .pix_rgb     (pix_rgb),
    .gamma_en    (gamma_en),
    .table_valid (tbl_valid),
    .lut_addr    (lut_addr),
    .lut_data    (lut_data),
    .out_valid   (out_valid),
    .out_rgb     (out_rgb)
  );

endmodule

// File: rtl/gamma_lut_checker.sv
module gamma_lut_checker #(
  parameter int NUM_CH = 3,
  parameter int CH_W   = 2,
  parameter int PIX_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_valid,
  input logic [CH_W-1:0]   pix_ch,
  input logic [PIX_W-1:0]  pix_rgb,
  input logic [NUM_CH-1:0] gamma_en,
  input logic              table_valid,
  input logic              out_valid,
  input logic [PIX_W-1:0]  out_rgb
);

  a_r1_reset_out: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && out_rgb == '0));

  a_r7_valid_hi: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  a_r7_valid_lo: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> $stable(out_rgb));

  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && 32'(pix_ch) < NUM_CH && !gamma_en[pix_ch]) |=> out_rgb == $past(pix_rgb));

  a_r9_invalid_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !table_valid) |=> out_rgb == $past(pix_rgb));

  a_r10_range_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && 32'(pix_ch) >= NUM_CH) |=> out_rgb == $past(pix_rgb));

endmodule

module gamma_host_checker #(
  parameter int ADDR_W = 12,
  parameter int TOTAL  = 2304
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_we,
  input logic [ADDR_W-1:0] addr_wdata,
  input logic              data_we,
  input logic [ADDR_W-1:0] ptr_q,
  input logic              inc_q
);

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !addr_we && inc_q && ptr_q < ADDR_W'(TOTAL)) |=> ptr_q == $past(ptr_q) + ADDR_W'(1));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !addr_we && !inc_q) |=> $stable(ptr_q));

  a_r4_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_we && addr_wdata >= ADDR_W'(TOTAL) && !data_we) |=> ($stable(ptr_q) && $stable(inc_q)));

  a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= ADDR_W'(TOTAL));

  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q == ADDR_W'(TOTAL) && !addr_we) |=> ptr_q == ADDR_W'(TOTAL));

endmodule

bind gamma_lut_top gamma_lut_checker #(
  .NUM_CH (NUM_CH),
  .CH_W   (CH_W),
  .PIX_W  (PIX_W)
) u_pix_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .pix_valid   (pix_valid),
  .pix_ch      (pix_ch),
  .pix_rgb     (pix_rgb),
  .gamma_en    (gamma_en),
  .table_valid (tbl_valid),
  .out_valid   (out_valid),
  .out_rgb     (out_rgb)
);

bind gamma_host_port gamma_host_checker #(
  .ADDR_W (ADDR_W),
  .TOTAL  (TOTAL)
) u_host_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_we    (addr_we),
  .addr_wdata (addr_wdata),
  .data_we    (data_we),
  .ptr_q      (ptr_q),
  .inc_q      (inc_q)
);

// File: tb/tb_gamma_lut_top.sv
module tb_gamma_lut_top;

  localparam int CLK_P  = 10;
  localparam int NUM_CH = 3;
  localparam int TOTAL  = NUM_CH * 768;

  logic        clk;
  logic        rst_n;
  logic        host_addr_we;
  logic [11:0] host_addr_wdata;
  logic        host_addr_autoinc;
  logic        host_data_we;
  logic [7:0]  host_data_wdata;
  logic [2:0]  gamma_en;
  logic        pix_valid;
  logic [1:0]  pix_ch;
  logic [23:0] pix_rgb;
  logic        out_valid;
  logic [23:0] out_rgb;

  gamma_lut_top dut (
    .clk               (clk),
    .rst_n             (rst_n),
    .host_addr_we      (host_addr_we),
    .host_addr_wdata   (host_addr_wdata),
    .host_addr_autoinc (host_addr_autoinc),
    .host_data_we      (host_data_we),
    .host_data_wdata   (host_data_wdata),
    .gamma_en          (gamma_en),
    .pix_valid         (pix_valid),
    .pix_ch            (pix_ch),
    .pix_rgb           (pix_rgb),
    .out_valid         (out_valid),
    .out_rgb           (out_rgb)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    chk_on  = 0;
  bit    done    = 0;
  string cur_req = "R1";

  // behavioural reference model
  int unsigned m_mem [TOTAL];
  int          m_ptr;
  bit          m_inc;
  bit          m_tv;
  bit          e_valid;
  logic [23:0] e_rgb;

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_inc = 0; m_tv = 0; e_valid = 0; e_rgb = '0;
    end else begin
      bit          n_valid;
      logic [23:0] n_rgb;
      bit          use_tab;
      bit          stored;
      n_valid = pix_valid;
      n_rgb   = e_rgb;
      if (pix_valid) begin
        use_tab = (pix_ch < NUM_CH) ? (gamma_en[pix_ch] && m_tv) : 1'b0;
        for (int c = 0; c < 3; c++) begin
          int v;
          v = int'(pix_rgb[(2-c)*8 +: 8]);
          n_rgb[(2-c)*8 +: 8] = use_tab ? 8'(m_mem[int'(pix_ch)*768 + c*256 + v]) : 8'(v);
        end
      end
      stored = host_data_we && (m_ptr < TOTAL);
      if (stored) m_mem[m_ptr] = host_data_wdata;
      if (host_addr_we && int'(host_addr_wdata) < TOTAL) begin
        m_ptr = int'(host_addr_wdata);
        m_inc = host_addr_autoinc;
      end else if (stored && m_inc) begin
        m_ptr = m_ptr + 1;
      end
      if (stored) m_tv = 1;
      else if (gamma_en == 3'b000) m_tv = 0;
      e_valid = n_valid;
      e_rgb   = n_rgb;
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      n_tests++;
      if (out_valid !== e_valid || out_rgb !== e_rgb) begin
        n_fail++;
        $display("FAIL %s: out_valid=%0b out_rgb=%06h expected valid=%0b rgb=%06h at %0t",
                 cur_req, out_valid, out_rgb, e_valid, e_rgb, $time);
      end
    end
  end

  task automatic drive(bit aw, int a, bit inc, bit dw, int d, bit pv, int ch, logic [23:0] rgb);
    @(negedge clk);
    host_addr_we      = aw;
    host_addr_wdata   = 12'(a);
    host_addr_autoinc = inc;
    host_data_we      = dw;
    host_data_wdata   = 8'(d);
    pix_valid         = pv;
    pix_ch            = 2'(ch);
    pix_rgb           = rgb;
  endtask

  task automatic idle(int n);
    repeat (n) drive(0, 0, 0, 0, 0, 0, 0, 24'h0);
  endtask

  task automatic set_addr(int a, bit inc);
    drive(1, a, inc, 0, 0, 0, 0, 24'h0);
  endtask

  task automatic wdata(int d);
    drive(0, 0, 0, 1, d, 0, 0, 24'h0);
  endtask

  task automatic pix(int ch, logic [23:0] rgb);
    drive(0, 0, 0, 0, 0, 1, ch, rgb);
  endtask

  function automatic int fill_val(int a);
    return (a * 37 + (a / 256) * 11 + 3) & 255;
  endfunction

  function automatic logic [23:0] pat(int k);
    return 24'((k * 32'h003B5D91 + 32'h00A1C3) ^ (k << 7));
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    host_addr_we = 0; host_addr_wdata = '0; host_addr_autoinc = 0;
    host_data_we = 0; host_data_wdata = '0; gamma_en = 3'b000;
    pix_valid = 0; pix_ch = '0; pix_rgb = '0;

    // R1: reset state
    cur_req = "R1";
    @(posedge clk);
    chk_on = 1;
    idle(3);
    rst_n = 1;
    idle(4);

    // R9: table not loaded yet, enables set: pixels pass unchanged
    cur_req = "R9";
    gamma_en = 3'b111;
    for (int k = 0; k < 12; k++) pix(k % 3, pat(k));
    idle(2);

    // R3 / R2: fill whole memory with auto-advance
    cur_req = "R3";
    set_addr(0, 1);
    for (int a = 0; a < TOTAL; a++) wdata(fill_val(a));
    idle(2);

    // R2: layout probes at component boundaries on every channel
    cur_req = "R2";
    for (int c = 0; c < 3; c++) begin
      pix(c, 24'h00FF80);
      pix(c, 24'hFF0001);
      pix(c, 24'h7F807F);
    end
    idle(2);

    // R6: independent component lookup, many patterns
    cur_req = "R6";
    for (int k = 0; k < 300; k++) pix(k % 3, pat(k + 40));
    idle(2);

    // R7: gaps between pixels, output holds
    cur_req = "R7";
    for (int k = 0; k < 20; k++) begin
      pix(k % 3, pat(k + 500));
      idle(1 + (k % 3));
    end

    // R8: channel 1 bypassed, others corrected
    cur_req = "R8";
    gamma_en = 3'b101;
    for (int k = 0; k < 30; k++) pix(k % 3, pat(k + 700));
    idle(2);
    gamma_en = 3'b111;

    // R10: out-of-range channel number
    cur_req = "R10";
    for (int k = 0; k < 8; k++) pix(3, pat(k + 900));
    pix(0, pat(3));
    idle(2);

    // R3: no auto-advance, repeated writes overwrite one entry
    cur_req = "R3";
    set_addr(5, 0);
    wdata(8'hAA);
    wdata(8'h55);
    pix(0, 24'h050505);
    pix(0, 24'h060606);
    idle(2);

    // R4: address beyond the table ignored, flag kept
    cur_req = "R4";
    set_addr(10, 1);
    set_addr(3000, 0);
    set_addr(4095, 0);
    wdata(8'h11);
    wdata(8'h22);
    pix(0, 24'h0A0B0C);
    pix(0, 24'h0B0A0C);
    idle(2);

    // R5: run off the end, nothing wraps to entry 0
    cur_req = "R5";
    set_addr(TOTAL - 1, 1);
    wdata(8'h99);
    wdata(8'h77);
    wdata(8'h66);
    pix(2, 24'h0000FF);
    pix(0, 24'h000000);
    pix(2, 24'hFFFFFF);
    idle(2);

    // R11: write and lookup of the same entry in one cycle
    cur_req = "R11";
    set_addr(20, 0);
    drive(0, 0, 0, 1, 8'hC3, 1, 0, 24'h140000);
    pix(0, 24'h140000);
    idle(2);

    // R9: all enables dropped, table lost until a write
    cur_req = "R9";
    gamma_en = 3'b000;
    idle(2);
    gamma_en = 3'b111;
    for (int k = 0; k < 9; k++) pix(k % 3, pat(k + 1100));
    wdata(8'h3C);
    for (int k = 0; k < 9; k++) pix(k % 3, pat(k + 1200));
    pix(0, 24'h140000);
    idle(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule